// File: doc/BRIEF.md
# RC Oscillator Period Calibration Engine

This engine trims a slow on-chip RC oscillator using a fast reference clock. It counts reference cycles across a fixed window of slow-clock rising edges. The count in the reference domain is the slow clock's period, scaled by the window length.

A calibration starts with a one-cycle `start` pulse and runs in two phases:

- **Coarse phase.** The engine derives a signed trim code from one settled period reading. The code is the number of oscillator steps needed to bring the period to its target, and it saturates at the ends of its range.
- **Fine phase.** The engine holds that trim. It averages several settled readings and divides a fixed numerator by the average. The quotient is an unsigned 5.11 fixed-point divisor that a downstream fractional divider uses to make a 1024 Hz tick.

Every trim change is followed by a settling pause, because the period counter runs freely and is not aligned to the trim update. The analog oscillator itself is outside this block. `slow_clk` arrives asynchronously and is synchronized internally. All pins are plain control and status pins. There is no streaming interface, so there is no back-pressure.

Top module: `rc_cal_engine`

## Requirements
- R1: While reset is asserted, and after it is released until the first `start`, `trim` reads 0, `divisor` reads the reset value `DIV_RESET` (0x5000, i.e. 10.0 in 5.11 format) and `done` is low.
- R2: A `start` pulse seen while the engine is idle returns `trim` to 0 and `divisor` to `DIV_RESET`, and drops `done`, all on the clock edge that samples `start`.
- R3: The coarse trim is `(TARGET + STEP/2 - P0) / STEP`, where `P0` is the settled period reading taken with trim 0. The division is computed on the magnitude and truncates toward zero; the sign of the numerator is then applied.
- R4: The coarse trim saturates at +7 and at -8 for the 4-bit two's-complement code and never wraps.
- R5: Once the coarse trim has been applied, `trim` keeps that value through the fine phase and after completion, until the next accepted `start`.
- R6: The final `divisor` equals `floor(NUMER / A)`, clamped to 0xFFFF, where `A` is the mean of `SAMPLES` consecutive settled readings taken with the coarse trim applied. The mean is the sum shifted right by log2(`SAMPLES`).
- R7: `done` rises no earlier than the edge on which `divisor` takes its final value. Until then `divisor` stays at `DIV_RESET`. Afterwards `done` and `divisor` hold until the next `start`.
- R8: A period reading is the number of reference cycles between two window boundaries that are `WINDOW` slow rising edges apart. After the engine starts and after every trim change, `SETTLE` readings are discarded, so that no reading used spans a trim change.
- R9: A `start` pulse while a calibration is running is ignored: `trim` and `done` are unchanged, and the run completes with its normal results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock; all logic runs in this domain |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a calibration when idle |
| slow_clk | input | 1 | Slow RC clock, asynchronous to `clk_ref` |
| trim | output | TRIM_W | Signed trim code driven to the oscillator |
| divisor | output | DIV_W | Unsigned 5.11 fractional divisor for the 1024 Hz tick |
| done | output | 1 | High once a calibration has finished, until the next start |

## Verification
The oscillator model sets each slow period from the current trim. Its base period is swept over thirteen offsets from far too fast to far too slow:

- **Exact multiples of the trim step** separate correct rounding from off-by-one results.
- **Offsets that fall between steps** separate truncation toward zero from floor division on both signs.
- **The extreme offsets** drive the trim into its positive and negative saturation limits.

Because every run begins at an arbitrary phase of the slow clock, the exact trim and divisor in every run also show whether the partial and straddling windows are discarded. A separate run pulses `start` during the fine phase, which separates ignoring that pulse from restarting the calibration.

// File: rtl/rcc_pkg.sv
package rcc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE_A,
    ST_TUNE_DIV,
    ST_SETTLE_B,
    ST_ACCUM,
    ST_FINE_DIV
  } cal_state_t;

endpackage

// File: rtl/rcc_edge_sync.sv
module rcc_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);

  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= async_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise = sync_q & ~prev_q;

endmodule

// File: rtl/rcc_period_meter.sv
module rcc_period_meter #(
  parameter int WINDOW   = 16,
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rise,
  output logic [PERIOD_W-1:0] period,
  output logic                vld
);

  localparam int EW = (WINDOW > 1) ? $clog2(WINDOW) : 1;
  localparam logic [PERIOD_W-1:0] CYC_MAX = '1;

  logic [EW-1:0]       edge_cnt;
  logic [PERIOD_W-1:0] cyc_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_cnt <= '0;
      cyc_cnt  <= '0;
      period   <= '0;
      vld      <= 1'b0;
    end else begin
      vld <= 1'b0;
      if (cyc_cnt != CYC_MAX) cyc_cnt <= cyc_cnt + 1'b1;
      if (rise) begin
        if (edge_cnt == EW'(WINDOW - 1)) begin
          edge_cnt <= '0;
          period   <= cyc_cnt;
          cyc_cnt  <= PERIOD_W'(1);
          vld      <= 1'b1;
        end else begin
          edge_cnt <= edge_cnt + 1'b1;
        end
      end
    end
  end

  AST_VLD_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    vld |=> !vld); // R8

endmodule

// File: rtl/rcc_divider.sv
module rcc_divider #(
  parameter int NUM_W = 32,
  parameter int DEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             busy,
  output logic             fin,
  output logic [NUM_W-1:0] quo
);

  localparam int CW = $clog2(NUM_W + 1);

  logic [DEN_W:0]   rem;
  logic [NUM_W-1:0] q;
  logic [CW-1:0]    cnt;
  logic [DEN_W+1:0] rem_sh;
  logic [DEN_W+1:0] den_x;

  assign rem_sh = {rem, q[NUM_W-1]};
  assign den_x  = {2'b00, den};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem  <= '0;
      q    <= '0;
      cnt  <= '0;
      busy <= 1'b0;
      fin  <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go && !busy) begin
        rem  <= '0;
        q    <= num;
        cnt  <= CW'(NUM_W);
        busy <= 1'b1;
      end else if (busy) begin
        if (rem_sh >= den_x) begin
          rem <= (DEN_W + 1)'(rem_sh - den_x);
          q   <= {q[NUM_W-2:0], 1'b1};
        end else begin
          rem <= rem_sh[DEN_W:0];
          q   <= {q[NUM_W-2:0], 1'b0};
        end
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end
      end
    end
  end

  assign quo = q;

  AST_GO_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !busy); // R6

endmodule

// File: rtl/rc_cal_engine.sv
module rc_cal_engine
  import rcc_pkg::*;
#(
  parameter int          WINDOW     = 16,
  parameter int          PERIOD_W   = 16,
  parameter int          TARGET     = 19200,
  parameter int          STEP       = 800,
  parameter int unsigned NUMER      = 384000000,
  parameter int          SAMPLES    = 8,
  parameter int          SETTLE     = 2,
  parameter int          TRIM_W     = 4,
  parameter int          DIV_W      = 16,
  parameter int          DIV_RESET  = 'h5000,
  parameter int          TRIM_RESET = 0
) (
  input  logic                     clk_ref,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     slow_clk,
  output logic signed [TRIM_W-1:0] trim,
  output logic [DIV_W-1:0]         divisor,
  output logic                     done
);

  localparam int NUM_W = 32;
  localparam int SLOG  = (SAMPLES > 1) ? $clog2(SAMPLES) : 0;
  localparam int SUM_W = PERIOD_W + SLOG;
  localparam int SC_W  = $clog2(SETTLE + 1);
  localparam int SN_W  = $clog2(SAMPLES + 1);
  localparam int BIAS  = TARGET + STEP / 2;
  localparam int TPOS  = 2 ** (TRIM_W - 1) - 1;
  localparam int TNEG  = 2 ** (TRIM_W - 1);
  localparam int DW    = PERIOD_W + 2;

  logic                rise;
  logic [PERIOD_W-1:0] period;
  logic                per_vld;

  logic                dv_go, dv_busy, dv_fin;
  logic [NUM_W-1:0]    dv_num, dv_quo;
  logic [PERIOD_W-1:0] dv_den;

  cal_state_t               state;
  logic [SC_W-1:0]          settle_cnt;
  logic [SN_W-1:0]          samp_cnt;
  logic [SUM_W-1:0]         sum;
  logic                     tune_neg;
  logic signed [TRIM_W-1:0] trim_q;
  logic [DIV_W-1:0]         div_q;
  logic                     done_q;

  logic signed [DW-1:0] diff;
  logic [DW-1:0]        mag;
  logic [SUM_W-1:0]     next_sum;

  rcc_edge_sync u_sync (
    .clk      (clk_ref),
    .rst_n    (rst_n),
    .async_in (slow_clk),
    .rise     (rise)
  );

  rcc_period_meter #(.WINDOW(WINDOW), .PERIOD_W(PERIOD_W)) u_meter (
    .clk    (clk_ref),
    .rst_n  (rst_n),
    .rise   (rise),
    .period (period),
    .vld    (per_vld)
  );

  rcc_divider #(.NUM_W(NUM_W), .DEN_W(PERIOD_W)) u_div (
    .clk   (clk_ref),
    .rst_n (rst_n),
    .go    (dv_go),
    .num   (dv_num),
    .den   (dv_den),
    .busy  (dv_busy),
    .fin   (dv_fin),
    .quo   (dv_quo)
  );

  always_comb begin
    diff     = $signed(DW'(BIAS)) - $signed({2'b00, period});
    mag      = diff[DW-1] ? DW'(-diff) : DW'(diff);
    next_sum = sum + SUM_W'(period);
  end

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      settle_cnt <= '0;
      samp_cnt   <= '0;
      sum        <= '0;
      tune_neg   <= 1'b0;
      trim_q     <= TRIM_W'(TRIM_RESET);
      div_q      <= DIV_W'(DIV_RESET);
      done_q     <= 1'b0;
      dv_go      <= 1'b0;
      dv_num     <= '0;
      dv_den     <= '0;
    end else begin
      dv_go <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            trim_q     <= TRIM_W'(TRIM_RESET);
            div_q      <= DIV_W'(DIV_RESET);
            done_q     <= 1'b0;
            settle_cnt <= '0;
            state      <= ST_SETTLE_A;
          end
        end
        ST_SETTLE_A: begin
          if (per_vld) begin
            if (settle_cnt == SC_W'(SETTLE)) begin
              tune_neg <= diff[DW-1];
              dv_num   <= NUM_W'(mag);
              dv_den   <= PERIOD_W'(STEP);
              dv_go    <= 1'b1;
              state    <= ST_TUNE_DIV;
            end else begin
              settle_cnt <= settle_cnt + 1'b1;
            end
          end
        end
        ST_TUNE_DIV: begin
          if (dv_fin) begin
            if (!tune_neg)
              trim_q <= (dv_quo > NUM_W'(TPOS)) ? TRIM_W'(TPOS) : dv_quo[TRIM_W-1:0];
            else
              trim_q <= (dv_quo > NUM_W'(TNEG)) ? TRIM_W'(TNEG)
                                                : TRIM_W'(0) - dv_quo[TRIM_W-1:0];
            settle_cnt <= '0;
            state      <= ST_SETTLE_B;
          end
        end
        ST_SETTLE_B: begin
          if (per_vld) begin
            if (settle_cnt == SC_W'(SETTLE)) begin
              sum      <= SUM_W'(period);
              samp_cnt <= SN_W'(1);
              state    <= ST_ACCUM;
            end else begin
              settle_cnt <= settle_cnt + 1'b1;
            end
          end
        end
        ST_ACCUM: begin
          if (per_vld) begin
            sum      <= next_sum;
            samp_cnt <= samp_cnt + 1'b1;
            if (samp_cnt == SN_W'(SAMPLES - 1)) begin
              dv_num <= NUM_W'(NUMER);
              dv_den <= PERIOD_W'(next_sum >> SLOG);
              dv_go  <= 1'b1;
              state  <= ST_FINE_DIV;
            end
          end
        end
        ST_FINE_DIV: begin
          if (dv_fin) begin
            div_q  <= (|dv_quo[NUM_W-1:DIV_W]) ? '1 : dv_quo[DIV_W-1:0];
            done_q <= 1'b1;
            state  <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign trim    = trim_q;
  assign divisor = div_q;
  assign done    = done_q;

  AST_RESTART_CLEARS: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (start && state == ST_IDLE) |=>
      (!done && divisor == DIV_W'(DIV_RESET) && trim == TRIM_W'(TRIM_RESET))); // R2
  AST_TRIM_FROZEN: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (state == ST_ACCUM || state == ST_FINE_DIV) |=> $stable(trim)); // R5
  AST_DONE_HOLD: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (done && !start) |=> done); // R7
  AST_DIV_HELD: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (done && !start) |=> $stable(divisor)); // R7
  AST_BUSY_START_IGNORED: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (start && (state == ST_SETTLE_B || state == ST_ACCUM || state == ST_FINE_DIV))
      |=> (state != ST_SETTLE_A)); // R9

endmodule

// File: tb/test_rc_cal_engine.sv
module test_rc_cal_engine;

  localparam int WIN = 4;
  localparam int TGT = 240;
  localparam int STP = 20;
  localparam int NUM = 4800000;
  localparam int OSC_STEP = STP / WIN;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic slow = 1'b0;
  logic signed [3:0] trim;
  logic [15:0] divisor;
  logic done;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  rc_cal_engine #(.WINDOW(WIN), .TARGET(TGT), .STEP(STP), .NUMER(NUM)) i_rc_cal_engine (
    .clk_ref  (clk),
    .rst_n    (rst_n),
    .start    (start),
    .slow_clk (slow),
    .trim     (trim),
    .divisor  (divisor),
    .done     (done)
  );

  // Oscillator model: each slow period (in reference cycles) is fixed at its rising edge.
  int base_p = 60;
  int ph = 0;
  int cur_p = 60;
  always @(negedge clk) begin
    if (ph == 0) begin
      cur_p = base_p + OSC_STEP * int'(trim);
      slow = 1'b1;
    end
    if (ph == cur_p / 2) slow = 1'b0;
    ph = (ph + 1 >= cur_p) ? 0 : ph + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_trim(input int b);
    int d = TGT + STP / 2 - WIN * b;
    int q = (d < 0 ? -d : d) / STP;
    int r = (d < 0) ? -q : q;
    if (r > 7) r = 7;
    if (r < -8) r = -8;
    return r;
  endfunction

  function automatic int exp_div(input int b, input int t);
    int avg = WIN * (b + OSC_STEP * t);
    int q = NUM / avg;
    if (q > 65535) q = 65535;
    return q;
  endfunction

  task automatic raw_pulse();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic start_checked();
    raw_pulse();
    chk("R2 trim after start", int'(trim), 0);
    chk("R2 divisor after start", int'(divisor), 'h5000);
    chk("R2 done after start", int'(done), 0);
  endtask

  task automatic wait_done(output bit ok, output int early);
    ok = 1'b0;
    early = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (done) begin
        ok = 1'b1;
        break;
      end
      if (divisor != 16'h5000) early++;
    end
  endtask

  task automatic run_case(input int k);
    bit ok;
    int early;
    int t, dv;
    int held;
    base_p = 60 + k;
    t = exp_trim(base_p);
    dv = exp_div(base_p, t);
    start_checked();
    wait_done(ok, early);
    chk("R7 done reached", int'(ok), 1);
    chk("R7 divisor unchanged before done", early, 0);
    // exact values also require discarded partial/straddling windows (R8)
    if (t == 7 || t == -8) chk("R4 saturated trim", int'(trim), t);
    else chk("R3 coarse trim", int'(trim), t);
    chk("R6 divisor", int'(divisor), dv);
    held = int'(divisor);
    repeat (40) @(negedge clk);
    chk("R7 done holds", int'(done), 1);
    chk("R7 divisor holds", int'(divisor), held);
    chk("R5 trim holds after done", int'(trim), t);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit ok;
    int early;
    int t;
    int ks[13] = '{-40, -30, -20, -12, -5, 0, 3, 7, 15, 25, 35, 45, 56};
    repeat (3) @(negedge clk);
    chk("R1 trim in reset", int'(trim), 0);
    chk("R1 divisor in reset", int'(divisor), 'h5000);
    chk("R1 done in reset", int'(done), 0);
    rst_n = 1'b1;
    repeat (300) @(negedge clk);
    chk("R1 trim idle", int'(trim), 0);
    chk("R1 divisor idle", int'(divisor), 'h5000);
    chk("R1 done idle", int'(done), 0);

    foreach (ks[i]) run_case(ks[i]);

    // R9: start during the fine phase is ignored
    base_p = 85;
    t = exp_trim(base_p);
    start_checked();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (trim != 4'sd0) break;
    end
    repeat (600) @(negedge clk);
    chk("R5 trim held in fine phase", int'(trim), t);
    raw_pulse();
    chk("R9 trim after busy start", int'(trim), t);
    chk("R9 done after busy start", int'(done), 0);
    wait_done(ok, early);
    chk("R9 run completes", int'(ok), 1);
    chk("R9 divisor after busy start", int'(divisor), exp_div(base_p, t));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule